// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 memory device from power-up to an operational state before the normal memory controller is given the command bus. After reset it walks a fixed, ordered list of steps. The first two steps set the device control pins. The next four write mode registers. The last step starts a long ZQ calibration. Each step can be followed by its own wait, counted in clock cycles by a single down-counter. When the list is exhausted the block raises a done flag. From then on it passes the controller's command, address and bank straight to the DFI-style command port, and it keeps clock-enable, termination and reset release high.

The contents of the mode registers come in on inputs. The two timing-critical registers (MR0 and MR1) are assembled inside the block from encoded fields. MR2 and MR3 are taken as raw words. The parameter `WAIT_SHIFT` divides every wait by a power of two so that simulations finish quickly. Production builds keep it at 0.

Top module: `dram_init_seq`

## Requirements
- R1: While `rst_ni` is low, `dfi_reset_n_o`, `dfi_cke_o` and `dfi_odt_o` are low, no command strobe is asserted and `init_done_o` is low.
- R2: The first clock after reset release drives `dfi_reset_n_o` and `dfi_odt_o` high with `dfi_cke_o` low. `dfi_cke_o` goes high exactly 1 + (50000 >> WAIT_SHIFT) cycles later, and `dfi_reset_n_o` was already high in the cycle before.
- R3: Mode registers are loaded in the order MR2, MR3, MR1, MR0 in four consecutive cycles. The first load comes (10000 >> WAIT_SHIFT) cycles after `dfi_cke_o` rises. Each load asserts cs, we, cas and ras together, puts the register number on `dfi_bank_o` and the register value on `dfi_addr_o`. MR2 is `mr2_val_i` and MR3 is `mr3_val_i`. Internally a command is a 4-bit vector with cs at bit 0, we at bit 1, cas at bit 2 and ras at bit 3, where 1 means asserted.
- R4: MR0 has bits 1:0 zero, CAS-latency code bit 0 at bit 2, code bits 3:1 at bits 6:4, bit 8 (DLL reset) set, and the write-recovery code at bits 11:9. All other bits are zero.
- R5: The write-recovery code comes from `wr_cycles_i` after raising it to at least 5. The mapping is: 5–8 give 1–4, 9–10 give 5, 11–12 give 6, 13–14 give 7, and 15 or more give 0.
- R6: MR1 has `ron_code_i` bit 0 at bit 1 and bit 1 at bit 5, and `rtt_code_i` bits 0, 1, 2 at bits 2, 6, 9. All other bits are zero.
- R7: ZQ calibration is issued 1 + (200 >> WAIT_SHIFT) cycles after the MR0 load. It asserts only cs and we, with address 0x0400 and bank 0.
- R8: Every sequencer command lasts exactly one cycle. Until done, no strobe, address or bank bit is driven outside those cycles, and the controller inputs have no effect on the port.
- R9: `init_done_o` rises 1 + (200 >> WAIT_SHIFT) cycles after the ZQ command and stays high. After that the port carries the controller inputs unchanged, and `dfi_cke_o`, `dfi_odt_o` and `dfi_reset_n_o` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cl_code_i | input | 4 | CAS-latency code for MR0 |
| wr_cycles_i | input | 5 | Write recovery in clock cycles |
| ron_code_i | input | 2 | Output drive-strength code for MR1 |
| rtt_code_i | input | 3 | Nominal termination code for MR1 |
| mr2_val_i | input | ADDR_W | Raw MR2 value |
| mr3_val_i | input | ADDR_W | Raw MR3 value |
| mc_cs_i | input | 1 | Controller chip select |
| mc_we_i | input | 1 | Controller write enable |
| mc_cas_i | input | 1 | Controller column strobe |
| mc_ras_i | input | 1 | Controller row strobe |
| mc_addr_i | input | ADDR_W | Controller address |
| mc_bank_i | input | BANK_W | Controller bank address |
| dfi_cs_o | output | 1 | Chip select to PHY |
| dfi_we_o | output | 1 | Write enable to PHY |
| dfi_cas_o | output | 1 | Column strobe to PHY |
| dfi_ras_o | output | 1 | Row strobe to PHY |
| dfi_addr_o | output | ADDR_W | Address to PHY |
| dfi_bank_o | output | BANK_W | Bank address to PHY |
| dfi_cke_o | output | 1 | Clock enable to device |
| dfi_odt_o | output | 1 | On-die termination to device |
| dfi_reset_n_o | output | 1 | Device reset, active low |
| init_done_o | output | 1 | Sequence complete; port owned by controller |

## Verification
Two things can fall in the same cycle. The controller may drive the port while the sequencer issues one of its one-cycle commands, and the hand-over at done coincides with whatever the controller presents at that moment. To provoke this, the bench holds every controller strobe asserted, with a non-zero address and bank, for the whole sequence. During init it requires that the port shows exactly the sequencer's command in issue cycles and all zeros in every wait cycle. In the first done cycle it requires that the port equals the controller inputs, and it changes those inputs once more to confirm the pass-through.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [2:0] {
    ST_UNRESET  = 3'd0,
    ST_CKE_ON   = 3'd1,
    ST_LOAD_MR2 = 3'd2,
    ST_LOAD_MR3 = 3'd3,
    ST_LOAD_MR1 = 3'd4,
    ST_LOAD_MR0 = 3'd5,
    ST_ZQ_CAL   = 3'd6,
    ST_DONE     = 3'd7
  } step_e;

  // bit 0 cs, bit 1 we, bit 2 cas, bit 3 ras; 1 = asserted
  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic cs;
  } cmd_t;

  typedef struct packed {
    logic rst_n;
    logic odt;
    logic cke;
  } pins_t;

  localparam cmd_t CMD_NONE    = cmd_t'(4'b0000);
  localparam cmd_t CMD_LOAD_MR = cmd_t'(4'b1111);
  localparam cmd_t CMD_ZQ      = cmd_t'(4'b0011);

  localparam int unsigned BASE_WAIT_UNRESET = 50000;
  localparam int unsigned BASE_WAIT_CKE     = 10000;
  localparam int unsigned BASE_WAIT_MR0     = 200;
  localparam int unsigned BASE_WAIT_ZQ      = 200;
  localparam int          WAIT_W            = $clog2(BASE_WAIT_UNRESET + 1);

  function automatic logic [WAIT_W-1:0] step_wait(step_e s, int unsigned shift);
    int unsigned base;
    case (s)
      ST_UNRESET:  base = BASE_WAIT_UNRESET;
      ST_CKE_ON:   base = BASE_WAIT_CKE;
      ST_LOAD_MR0: base = BASE_WAIT_MR0;
      ST_ZQ_CAL:   base = BASE_WAIT_ZQ;
      default:     base = 0;
    endcase
    return WAIT_W'(base >> shift);
  endfunction

endpackage

// File: rtl/dram_init_mr_fmt.sv
module dram_init_mr_fmt #(
  parameter int ADDR_W = 14
) (
  input  logic [3:0]        cl_code_i,
  input  logic [4:0]        wr_cycles_i,
  input  logic [1:0]        ron_i,
  input  logic [2:0]        rtt_i,
  output logic [ADDR_W-1:0] mr0_o,
  output logic [ADDR_W-1:0] mr1_o
);
  localparam int FMT_W = 16;

  logic [4:0]       wr_sat;
  logic [2:0]       wr_code;
  logic [FMT_W-1:0] mr0_f, mr1_f;

  always_comb begin
    wr_sat = wr_cycles_i;
    if (wr_sat < 5'd5)  wr_sat = 5'd5;
    if (wr_sat > 5'd16) wr_sat = 5'd16;
    // 5..8 linear; above 8 only even values exist, odd rounds up; 16 wraps to 0
    if (wr_sat <= 5'd8) wr_code = 3'(wr_sat - 5'd4);
    else                wr_code = 3'((wr_sat + 5'd1) >> 1);
  end

  always_comb begin
    mr0_f        = '0;
    mr0_f[2]     = cl_code_i[0];
    mr0_f[6:4]   = cl_code_i[3:1];
    mr0_f[8]     = 1'b1;
    mr0_f[11:9]  = wr_code;
    mr1_f        = '0;
    mr1_f[1]     = ron_i[0];
    mr1_f[5]     = ron_i[1];
    mr1_f[2]     = rtt_i[0];
    mr1_f[6]     = rtt_i[1];
    mr1_f[9]     = rtt_i[2];
  end

  assign mr0_o = ADDR_W'(mr0_f);
  assign mr1_o = ADDR_W'(mr1_f);

endmodule

// File: rtl/dram_init_walk.sv
module dram_init_walk
  import dram_init_pkg::*;
#(
  parameter int unsigned WAIT_SHIFT = 0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  output step_e step_o,
  output logic  issue_o,
  output logic  done_o
);
  step_e             step_q;
  logic              first_q;
  logic [WAIT_W-1:0] wait_q;
  logic [WAIT_W-1:0] cur_wait;

  assign cur_wait = step_wait(step_q, WAIT_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q  <= ST_UNRESET;
      first_q <= 1'b1;
      wait_q  <= '0;
    end else if (step_q != ST_DONE) begin
      if (first_q) begin
        if (cur_wait == '0) begin
          step_q <= step_e'(step_q + 3'd1);
        end else begin
          wait_q  <= cur_wait;
          first_q <= 1'b0;
        end
      end else begin
        wait_q <= wait_q - WAIT_W'(1);
        if (wait_q == WAIT_W'(1)) begin
          step_q  <= step_e'(step_q + 3'd1);
          first_q <= 1'b1;
        end
      end
    end
  end

  assign step_o  = step_q;
  assign issue_o = first_q && (step_q != ST_DONE);
  assign done_o  = (step_q == ST_DONE);

  assert_wait_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!first_q && wait_q > WAIT_W'(1)) |=> (step_q == $past(step_q)));

  assert_step_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q != ST_DONE) |=> (step_q == $past(step_q) || step_q == step_e'($past(step_q) + 3'd1)));

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q == ST_DONE) |=> (step_q == ST_DONE));

endmodule

// File: rtl/dram_init_step_dec.sv
module dram_init_step_dec
  import dram_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  step_e             step_i,
  input  logic              issue_i,
  input  logic [ADDR_W-1:0] mr0_i,
  input  logic [ADDR_W-1:0] mr1_i,
  input  logic [ADDR_W-1:0] mr2_i,
  input  logic [ADDR_W-1:0] mr3_i,
  output cmd_t              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              pins_load_o,
  output pins_t             pins_o
);
  localparam logic [ADDR_W-1:0] ZQ_ADDR = ADDR_W'(11'h400);

  always_comb begin
    cmd_o       = CMD_NONE;
    addr_o      = '0;
    bank_o      = '0;
    pins_load_o = 1'b0;
    pins_o      = '0;
    case (step_i)
      ST_UNRESET: begin
        pins_load_o  = issue_i;
        pins_o.rst_n = 1'b1;
        pins_o.odt   = 1'b1;
      end
      ST_CKE_ON: begin
        pins_load_o  = issue_i;
        pins_o.rst_n = 1'b1;
        pins_o.odt   = 1'b1;
        pins_o.cke   = 1'b1;
      end
      ST_LOAD_MR2: if (issue_i) begin
        cmd_o = CMD_LOAD_MR; addr_o = mr2_i; bank_o = BANK_W'(2);
      end
      ST_LOAD_MR3: if (issue_i) begin
        cmd_o = CMD_LOAD_MR; addr_o = mr3_i; bank_o = BANK_W'(3);
      end
      ST_LOAD_MR1: if (issue_i) begin
        cmd_o = CMD_LOAD_MR; addr_o = mr1_i; bank_o = BANK_W'(1);
      end
      ST_LOAD_MR0: if (issue_i) begin
        cmd_o = CMD_LOAD_MR; addr_o = mr0_i; bank_o = BANK_W'(0);
      end
      ST_ZQ_CAL: if (issue_i) begin
        cmd_o = CMD_ZQ; addr_o = ZQ_ADDR;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dram_init_port_mux.sv
module dram_init_port_mux
  import dram_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3
) (
  input  logic              own_i,
  input  cmd_t              seq_cmd_i,
  input  logic [ADDR_W-1:0] seq_addr_i,
  input  logic [BANK_W-1:0] seq_bank_i,
  input  cmd_t              mc_cmd_i,
  input  logic [ADDR_W-1:0] mc_addr_i,
  input  logic [BANK_W-1:0] mc_bank_i,
  output cmd_t              cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BANK_W-1:0] bank_o
);
  assign cmd_o  = own_i ? seq_cmd_i  : mc_cmd_i;
  assign addr_o = own_i ? seq_addr_i : mc_addr_i;
  assign bank_o = own_i ? seq_bank_i : mc_bank_i;
endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int          ADDR_W     = 14,
  parameter int          BANK_W     = 3,
  parameter int unsigned WAIT_SHIFT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        cl_code_i,
  input  logic [4:0]        wr_cycles_i,
  input  logic [1:0]        ron_code_i,
  input  logic [2:0]        rtt_code_i,
  input  logic [ADDR_W-1:0] mr2_val_i,
  input  logic [ADDR_W-1:0] mr3_val_i,
  input  logic              mc_cs_i,
  input  logic              mc_we_i,
  input  logic              mc_cas_i,
  input  logic              mc_ras_i,
  input  logic [ADDR_W-1:0] mc_addr_i,
  input  logic [BANK_W-1:0] mc_bank_i,
  output logic              dfi_cs_o,
  output logic              dfi_we_o,
  output logic              dfi_cas_o,
  output logic              dfi_ras_o,
  output logic [ADDR_W-1:0] dfi_addr_o,
  output logic [BANK_W-1:0] dfi_bank_o,
  output logic              dfi_cke_o,
  output logic              dfi_odt_o,
  output logic              dfi_reset_n_o,
  output logic              init_done_o
);
  step_e             step;
  logic              issue, done;
  logic [ADDR_W-1:0] mr0, mr1, seq_addr;
  logic [BANK_W-1:0] seq_bank;
  cmd_t              seq_cmd, mc_cmd, out_cmd;
  logic              pins_load;
  pins_t             pins_nxt, pins_q;

  dram_init_mr_fmt #(.ADDR_W(ADDR_W)) i_mr_fmt (
    .cl_code_i  (cl_code_i),
    .wr_cycles_i(wr_cycles_i),
    .ron_i      (ron_code_i),
    .rtt_i      (rtt_code_i),
    .mr0_o      (mr0),
    .mr1_o      (mr1)
  );

  dram_init_walk #(.WAIT_SHIFT(WAIT_SHIFT)) i_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_o (step),
    .issue_o(issue),
    .done_o (done)
  );

  dram_init_step_dec #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_dec (
    .step_i     (step),
    .issue_i    (issue),
    .mr0_i      (mr0),
    .mr1_i      (mr1),
    .mr2_i      (mr2_val_i),
    .mr3_i      (mr3_val_i),
    .cmd_o      (seq_cmd),
    .addr_o     (seq_addr),
    .bank_o     (seq_bank),
    .pins_load_o(pins_load),
    .pins_o     (pins_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pins_q <= '0;
    else if (pins_load) pins_q <= pins_nxt;
  end

  assign mc_cmd = '{ras: mc_ras_i, cas: mc_cas_i, we: mc_we_i, cs: mc_cs_i};

  dram_init_port_mux #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) i_mux (
    .own_i     (!done),
    .seq_cmd_i (seq_cmd),
    .seq_addr_i(seq_addr),
    .seq_bank_i(seq_bank),
    .mc_cmd_i  (mc_cmd),
    .mc_addr_i (mc_addr_i),
    .mc_bank_i (mc_bank_i),
    .cmd_o     (out_cmd),
    .addr_o    (dfi_addr_o),
    .bank_o    (dfi_bank_o)
  );

  assign dfi_cs_o      = out_cmd.cs;
  assign dfi_we_o      = out_cmd.we;
  assign dfi_cas_o     = out_cmd.cas;
  assign dfi_ras_o     = out_cmd.ras;
  assign dfi_cke_o     = pins_q.cke;
  assign dfi_odt_o     = pins_q.odt;
  assign dfi_reset_n_o = pins_q.rst_n;
  assign init_done_o   = done;

  assert_cke_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dfi_cke_o) |-> $past(dfi_reset_n_o));

  assert_mr_bank_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_o && dfi_cs_o && dfi_we_o && dfi_cas_o && dfi_ras_o) |-> (dfi_bank_o <= BANK_W'(3)));

  assert_zq_shape_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_o && dfi_we_o && !dfi_ras_o) |-> (dfi_cs_o && !dfi_cas_o &&
      dfi_addr_o == ADDR_W'(11'h400) && dfi_bank_o == '0));

  assert_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_done_o && !issue) |-> !(dfi_cs_o || dfi_we_o || dfi_cas_o || dfi_ras_o));

  assert_pins_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |-> (dfi_cke_o && dfi_odt_o && dfi_reset_n_o));

endmodule

// File: tb/test_dram_init_seq.sv
module test_dram_init_seq;
  localparam int ADDR_W = 14;
  localparam int BANK_W = 3;
  localparam int SHIFT  = 4;
  localparam int W_RST  = 50000 >> SHIFT;
  localparam int W_CKE  = 10000 >> SHIFT;
  localparam int W_MR0  = 200 >> SHIFT;
  localparam int W_ZQ   = 200 >> SHIFT;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] cl_code_i = '0;
  logic [4:0] wr_cycles_i = '0;
  logic [1:0] ron_code_i = '0;
  logic [2:0] rtt_code_i = '0;
  logic [ADDR_W-1:0] mr2_val_i = '0, mr3_val_i = '0, mc_addr_i = '0;
  logic mc_cs_i = 0, mc_we_i = 0, mc_cas_i = 0, mc_ras_i = 0;
  logic [BANK_W-1:0] mc_bank_i = '0;
  logic dfi_cs_o, dfi_we_o, dfi_cas_o, dfi_ras_o, dfi_cke_o, dfi_odt_o, dfi_reset_n_o, init_done_o;
  logic [ADDR_W-1:0] dfi_addr_o;
  logic [BANK_W-1:0] dfi_bank_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  dram_init_seq #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .WAIT_SHIFT(SHIFT)) i_dram_init_seq (.*);

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  function automatic int exp_wr_code(int w);
    case (w)
      0, 1, 2, 3, 4, 5: return 1;
      6: return 2;
      7: return 3;
      8: return 4;
      9, 10: return 5;
      11, 12: return 6;
      13, 14: return 7;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_mr0(logic [3:0] cl, int w);
    return (int'(cl[0]) << 2) | (int'(cl[3:1]) << 4) | (1 << 8) | (exp_wr_code(w) << 9);
  endfunction

  function automatic int exp_mr1(logic [1:0] ron, logic [2:0] rtt);
    return (int'(ron[0]) << 1) | (int'(ron[1]) << 5) | (int'(rtt[0]) << 2) |
           (int'(rtt[1]) << 6) | (int'(rtt[2]) << 9);
  endfunction

  function automatic int cmd_bits();
    return {dfi_ras_o, dfi_cas_o, dfi_we_o, dfi_cs_o};
  endfunction

  // R1: reset state with controller inputs busy
  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(!dfi_reset_n_o && !dfi_cke_o && !dfi_odt_o, "R1 pins in reset",
        {dfi_reset_n_o, dfi_odt_o, dfi_cke_o}, 0);
    chk(cmd_bits() == 0, "R1 no strobe in reset", cmd_bits(), 0);
    chk(!init_done_o, "R1 done low in reset", init_done_o, 0);
  endtask

  task automatic t_full_run(input logic [3:0] cl, input int wr, input logic [1:0] ron,
                            input logic [2:0] rtt, input logic [ADDR_W-1:0] m2,
                            input logic [ADDR_W-1:0] m3);
    int rstn_t = -1, cke_t = -1, done_t = -1, n_cmd = 0, quiet_bad = 0, bad_at_rise = 0;
    int c_t[8], c_bits[8], c_addr[8], c_bank[8];
    int exp_addr[5], exp_bank[5], exp_bits[5];
    cl_code_i = cl; wr_cycles_i = 5'(wr); ron_code_i = ron; rtt_code_i = rtt;
    mr2_val_i = m2; mr3_val_i = m3;
    mc_cs_i = 1; mc_we_i = 1; mc_cas_i = 1; mc_ras_i = 1;
    mc_addr_i = 14'h2aaa; mc_bank_i = 3'd5;
    t_reset();
    rst_ni = 1'b1;
    for (int t = 1; t < 6000 && done_t < 0; t++) begin
      @(negedge clk_i);
      if (rstn_t < 0 && dfi_reset_n_o) begin
        rstn_t = t;
        if (dfi_cke_o || !dfi_odt_o) bad_at_rise = 1;
      end
      if (cke_t < 0 && dfi_cke_o) cke_t = t;
      if (init_done_o) done_t = t;
      else if (cmd_bits() != 0) begin
        if (n_cmd < 8) begin
          c_t[n_cmd] = t; c_bits[n_cmd] = cmd_bits();
          c_addr[n_cmd] = int'(dfi_addr_o); c_bank[n_cmd] = int'(dfi_bank_o);
        end
        n_cmd++;
      end else if (dfi_addr_o != 0 || dfi_bank_o != 0) quiet_bad++;
    end
    // R2
    chk(rstn_t == 1 && bad_at_rise == 0, "R2 reset release with odt, cke low", rstn_t, 1);
    chk(cke_t - rstn_t == 1 + W_RST, "R2 cke delay", cke_t - rstn_t, 1 + W_RST);
    chk(n_cmd == 5, "R8 command count", n_cmd, 5);
    if (n_cmd == 5) begin
      exp_addr = '{int'(m2), int'(m3), exp_mr1(ron, rtt), exp_mr0(cl, wr), 'h400};
      exp_bank = '{2, 3, 1, 0, 0};
      exp_bits = '{'hf, 'hf, 'hf, 'hf, 'h3};
      chk(c_t[0] - cke_t == W_CKE, "R3 MR2 after cke", c_t[0] - cke_t, W_CKE);
      for (int k = 1; k < 4; k++)
        chk(c_t[k] - c_t[k-1] == 1, "R3 back-to-back loads", c_t[k] - c_t[k-1], 1);
      for (int k = 0; k < 4; k++) begin
        chk(c_bits[k] == exp_bits[k], "R3 load strobes", c_bits[k], exp_bits[k]);
        chk(c_bank[k] == exp_bank[k], "R3 load bank", c_bank[k], exp_bank[k]);
      end
      chk(c_addr[0] == exp_addr[0], "R3 MR2 value", c_addr[0], exp_addr[0]);
      chk(c_addr[1] == exp_addr[1], "R3 MR3 value", c_addr[1], exp_addr[1]);
      chk(c_addr[2] == exp_addr[2], "R6 MR1 value", c_addr[2], exp_addr[2]);
      chk(c_addr[3] == exp_addr[3], "R4 R5 MR0 value", c_addr[3], exp_addr[3]);
      chk(c_t[4] - c_t[3] == 1 + W_MR0, "R7 ZQ delay", c_t[4] - c_t[3], 1 + W_MR0);
      chk(c_bits[4] == exp_bits[4] && c_addr[4] == exp_addr[4] && c_bank[4] == 0,
          "R7 ZQ shape", (c_bits[4] << 16) | c_addr[4], (exp_bits[4] << 16) | exp_addr[4]);
      chk(done_t - c_t[4] == 1 + W_ZQ, "R9 done delay", done_t - c_t[4], 1 + W_ZQ);
    end
    chk(quiet_bad == 0, "R8 idle port quiet", quiet_bad, 0);
    // R9: hand-over in first done cycle, then a new pattern
    chk(cmd_bits() == 'hf && dfi_addr_o == 14'h2aaa && dfi_bank_o == 3'd5,
        "R9 pass-through at done", cmd_bits(), 'hf);
    mc_cs_i = 1; mc_we_i = 0; mc_cas_i = 1; mc_ras_i = 0; mc_addr_i = 14'h0123; mc_bank_i = 3'd2;
    @(negedge clk_i);
    chk(cmd_bits() == 'h5 && dfi_addr_o == 14'h0123 && dfi_bank_o == 3'd2,
        "R9 pass-through new pattern", cmd_bits(), 'h5);
    repeat (5) @(negedge clk_i);
    chk(init_done_o && dfi_cke_o && dfi_odt_o && dfi_reset_n_o, "R9 done and pins held",
        {init_done_o, dfi_cke_o, dfi_odt_o, dfi_reset_n_o}, 'hf);
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_full_run(4'b0110, 3, 2'b01, 3'b101, 14'h0018, 14'h0000);   // R5 low clamp
    t_full_run(4'b1011, 11, 2'b10, 3'b010, 14'h0208, 14'h0004);  // R5 odd rounds up
    t_full_run(4'b0001, 20, 2'b11, 3'b111, 14'h3fff, 14'h1555);  // R5 high clamp
    t_full_run(4'b1110, 7, 2'b00, 3'b100, 14'h0040, 14'h0002);   // R5 linear range
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule